// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

A register-mapped pulse-width modulator with two independent channels that run from one shared clock. Software programs each channel through a common control word (clock divider selection, run enable, clock gate, output polarity, clock pass-through) and through a per-channel timing word. That timing word holds the cycle length minus one in its upper half and the active length in its lower half. The channel divides the clock by the selected factor, counts prescaled ticks across each cycle, and drives its output to the active level for the first part of the cycle.

A write to a timing word does not disturb a running waveform. The new value waits in a shadow register and takes over at the next cycle boundary. While it waits, a ready flag in the control word reads 1. A channel can also send the undivided clock straight to its pin, and this overrides every other setting.

Top module: `pwm_ctrl_top`

## Requirements
- R1: Byte address 0x0 is the control word, 0x4 is channel 0's timing word and 0x8 is channel 1's. A read asserted with `rdEn` returns the stored value on `rdData` one cycle later. In the control word, each channel keeps bits 3:0, 4, 5, 6 and 9 of its field, which starts at bit 15·n. Field bits 7 and 8, every other unlisted bit and every unmapped address read as 0.
- R2: A channel counts only when its enable bit (field bit 4) and its gate bit (field bit 6) are both 1. Otherwise its counters are held at zero and its output sits at the inactive level, which is the inverse of field bit 5. After reset every output is therefore 1.
- R3: Field bits 3:0 select the divider. Codes 0 to 4 divide by 120, 180, 240, 360 and 480. Codes 8 to 12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1.
- R4: Codes 5, 6, 7, 13 and 14 are invalid. They stop the channel exactly as a cleared enable bit does.
- R5: Timing word bits 31:16 hold P and bits 15:0 hold D. A cycle lasts P+1 prescaled ticks, and the output is active for ticks 0 to D-1, starting from the cycle in which counting begins.
- R6: Field bit 5 = 1 makes the active level high. Field bit 5 = 0 makes it low.
- R7: D ≥ P+1 gives a constant active output. D = 0 gives a constant inactive output.
- R8: Field bit 9 = 1 sends the block clock to that channel's output, whatever the other field bits hold.
- R9: A timing-word write sets the ready flag at control bit 28+n. The new value is loaded, and the flag cleared, at the end of the current cycle, or on the next clock when the channel is stopped.
- R10: The two channels are independent. Channel 1 is controlled only by its field at bits 24:15 and produces its own waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the PWM source clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| pwmOut | output | 2 | One PWM output per channel |

## Verification
A wrong counter state shows on the pin within one prescaled cycle. It appears as an active run whose length is not D times the divider, or as a low stretch whose length does not match P+1-D. The bench therefore measures run lengths from a known start edge rather than only sampling duty ratios. A shadow register loaded too early cuts the old cycle short, and one loaded too late stretches it, so the deferred-update case measures the old cycle's low time and then the new cycle's high time. A stuck ready flag is visible on the next control-word read.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int DIV_W     = 17;
  localparam int FIELD_W   = 10;
  localparam int CH_STRIDE = 15;
  localparam int RDY_BASE  = 28;
  localparam int B_EN      = 4;
  localparam int B_ACT     = 5;
  localparam int B_GATE    = 6;
  localparam int B_BYP     = 9;

  // control -> datapath strobes for one channel
  typedef struct packed {
    logic             run;
    logic             load;
    logic             bypass;
    logic             actHigh;
    logic [3:0]       presc;
    logic [CNT_W-1:0] prd;
    logic [CNT_W-1:0] dty;
  } chanCtl_t;

  // divider for a prescaler code; zero marks an invalid code
  function automatic logic [DIV_W-1:0] prescDiv(input logic [3:0] code);
    case (code)
      4'd0:    return DIV_W'(120);
      4'd1:    return DIV_W'(180);
      4'd2:    return DIV_W'(240);
      4'd3:    return DIV_W'(360);
      4'd4:    return DIV_W'(480);
      4'd8:    return DIV_W'(12000);
      4'd9:    return DIV_W'(24000);
      4'd10:   return DIV_W'(36000);
      4'd11:   return DIV_W'(48000);
      4'd12:   return DIV_W'(72000);
      4'd15:   return DIV_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] chWrap,
  output chanCtl_t          chCtl [NUM_CH]
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [FIELD_W-1:0] FIELD_MASK = FIELD_W'(10'h27F);

  logic [IDX_W-1:0]   wordIdx;
  logic               ctrlWr;
  logic [FIELD_W-1:0] field  [NUM_CH];
  logic [DATA_W-1:0]  shadow [NUM_CH];
  logic               pend   [NUM_CH];
  logic               wrCh   [NUM_CH];
  logic               runCh  [NUM_CH];
  logic               loadCh [NUM_CH];
  logic [DATA_W-1:0]  rdMux;

  assign wordIdx = addr[ADDR_W-1:2];
  assign ctrlWr  = wrEn && (wordIdx == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wrCh[c]   = wrEn && (wordIdx == IDX_W'(c + 1));
    assign runCh[c]  = field[c][B_EN] && field[c][B_GATE] && !field[c][B_BYP]
                       && (prescDiv(field[c][3:0]) != '0);
    assign loadCh[c] = pend[c] && (chWrap[c] || !runCh[c]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        field[c]  <= '0;
        shadow[c] <= '0;
        pend[c]   <= 1'b0;
      end else begin
        if (ctrlWr) field[c] <= wrData[c*CH_STRIDE +: FIELD_W] & FIELD_MASK;
        if (wrCh[c]) shadow[c] <= wrData;
        if (wrCh[c])        pend[c] <= 1'b1;
        else if (loadCh[c]) pend[c] <= 1'b0;
      end
    end

    assign chCtl[c] = '{run:     runCh[c],
                        load:    loadCh[c],
                        bypass:  field[c][B_BYP],
                        actHigh: field[c][B_ACT],
                        presc:   field[c][3:0],
                        prd:     shadow[c][DATA_W-1:CNT_W],
                        dty:     shadow[c][CNT_W-1:0]};

    // R9: a timing write always raises the ready flag
    a_r9_ready_on_write: assert property (@(posedge clk) disable iff (!rstN)
      wrCh[c] |=> pend[c]);
    // R9: a running channel keeps its pending value until the cycle boundary
    a_r9_hold_to_boundary: assert property (@(posedge clk) disable iff (!rstN)
      (pend[c] && runCh[c] && !chWrap[c] && !wrCh[c]) |=> pend[c]);
  end

  always_comb begin
    rdMux = '0;
    if (wordIdx == '0) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rdMux[c*CH_STRIDE +: FIELD_W] = field[c];
        rdMux[RDY_BASE + c]           = pend[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (wordIdx == IDX_W'(c + 1)) rdMux = shadow[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCtl_t ctl,
  output logic     wrap,
  output logic     pwmOut
);
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] divVal;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] livePrd;
  logic [CNT_W-1:0] liveDty;
  logic             tick;
  logic             inDuty;

  assign divVal = prescDiv(ctl.presc);
  assign tick   = ctl.run && (preCnt >= divVal - DIV_W'(1));
  assign wrap   = tick && (perCnt == livePrd);
  assign inDuty = ctl.run && (perCnt < liveDty);
  assign pwmOut = ctl.bypass ? clk : ~(inDuty ^ ctl.actHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      perCnt  <= '0;
      livePrd <= '0;
      liveDty <= '0;
    end else begin
      if (!ctl.run) begin
        preCnt <= '0;
        perCnt <= '0;
      end else begin
        preCnt <= tick ? '0 : preCnt + DIV_W'(1);
        if (tick) perCnt <= wrap ? '0 : perCnt + CNT_W'(1);
      end
      if (ctl.load) begin
        livePrd <= ctl.prd;
        liveDty <= ctl.dty;
      end
    end
  end

  // R2: a stopped channel holds both counters at zero
  a_r2_held_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (perCnt == '0 && preCnt == '0));
  // R5: the cycle counter never passes the live period length
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    perCnt <= livePrd);
  // R7: zero duty keeps a running output inactive
  a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && liveDty == '0) |-> (pwmOut == !ctl.actHigh));
  // R7: duty beyond the period keeps a running output active
  a_r7_full_duty: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && ({1'b0, liveDty} > {1'b0, livePrd})) |-> (pwmOut == ctl.actHigh));
endmodule

// File: rtl/pwm_ctrl_top.sv
`timescale 1ns/1ps
module pwm_ctrl_top
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCtl_t          chCtl [NUM_CH];
  logic [NUM_CH-1:0] chWrap;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .chWrap (chWrap),
    .chCtl  (chCtl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (chCtl[c]),
      .wrap   (chWrap[c]),
      .pwmOut (pwmOut[c])
    );
  end
endmodule

// File: tb/tb_pwm_ctrl_top.sv
`timescale 1ns/1ps
module tb_pwm_ctrl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  pwmOut;
  int          nChecks = 0;
  int          nFails = 0;

  localparam logic [31:0] EN = 32'h10, ACT = 32'h20, GATE = 32'h40, BYP = 32'h200;
  localparam logic [31:0] RUN1 = EN | ACT | GATE | 32'hF;

  always #10 clk = ~clk;

  pwm_ctrl_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic runLen(input int ch, input bit lvl, input int limit, output int n);
    n = 0;
    while (pwmOut[ch] == lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic countHigh(input int cycles, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < cycles; i++) begin
      c0 += int'(pwmOut[0]);
      c1 += int'(pwmOut[1]);
      @(negedge clk);
    end
  endtask

  task automatic startCh0(input logic [31:0] timing, input logic [31:0] ctrl);
    regWrite(4'h0, ACT);
    regWrite(4'h4, timing);
    regWrite(4'h0, ctrl);
  endtask

  task automatic testReset;
    logic [31:0] d;
    @(negedge clk);
    chk(pwmOut == 2'b11, "R2 reset outputs idle high", pwmOut, 2'b11);
    regRead(4'h0, d);
    chk(d == 32'h0, "R1 reset control word", d, 0);
  endtask

  task automatic testReadback;
    logic [31:0] d;
    regWrite(4'h0, 32'hFFFF_FFFF);
    regWrite(4'h8, 32'hABCD_1234);
    regRead(4'h0, d);
    chk(d == 32'h013F_827F, "R1 control keeps only defined bits", d, 32'h013F_827F);
    regRead(4'h8, d);
    chk(d == 32'hABCD_1234, "R1 timing word readback", d, 32'hABCD_1234);
    regRead(4'hC, d);
    chk(d == 32'h0, "R1 unmapped address reads zero", d, 0);
    regWrite(4'h0, 32'h0);
  endtask

  task automatic testGating;
    int n, h0, h1;
    regWrite(4'h4, 32'h0009_0003);
    regWrite(4'h0, ACT | EN | 32'hF);
    countHigh(40, h0, h1);
    chk(h0 == 0, "R2 enable without gate stays inactive", h0, 0);
    regWrite(4'h0, ACT | GATE | 32'hF);
    countHigh(40, h0, h1);
    chk(h0 == 0, "R2 gate without enable stays inactive", h0, 0);
    regWrite(4'h0, RUN1);
    runLen(0, 1'b1, 100, n);
    chk(n == 3, "R5 first active run equals duty", n, 3);
    runLen(0, 1'b0, 100, n);
    chk(n == 7, "R5 inactive run equals period minus duty", n, 7);
    countHigh(40, h0, h1);
    chk(h0 == 12, "R5 duty ratio over four cycles", h0, 12);
    regWrite(4'h0, ACT);
    chk(pwmOut[0] == 1'b0, "R2 stopped output at inactive low", pwmOut[0], 0);
    regWrite(4'h0, 32'h0);
    chk(pwmOut[0] == 1'b1, "R2 stopped output at inactive high", pwmOut[0], 1);
  endtask

  task automatic testPrescale;
    int n;
    startCh0(32'h0003_0001, EN | ACT | GATE | 32'h0);
    runLen(0, 1'b1, 200000, n);
    chk(n == 120, "R3 code 0 divides by 120", n, 120);
    startCh0(32'h0003_0001, EN | ACT | GATE | 32'h4);
    runLen(0, 1'b1, 200000, n);
    chk(n == 480, "R3 code 4 divides by 480", n, 480);
    startCh0(32'h0003_0001, EN | ACT | GATE | 32'h8);
    runLen(0, 1'b1, 200000, n);
    chk(n == 12000, "R3 code 8 divides by 12000", n, 12000);
  endtask

  task automatic testInvalid;
    int h0, h1;
    startCh0(32'h0003_0002, EN | ACT | GATE | 32'h5);
    countHigh(300, h0, h1);
    chk(h0 == 0, "R4 code 5 stops the channel", h0, 0);
    regWrite(4'h0, EN | ACT | GATE | 32'hD);
    countHigh(300, h0, h1);
    chk(h0 == 0, "R4 code 13 stops the channel", h0, 0);
  endtask

  task automatic testDutyEdges;
    int h0, h1;
    startCh0(32'h0004_0007, RUN1);
    countHigh(100, h0, h1);
    chk(h0 == 100, "R7 duty above period is always active", h0, 100);
    startCh0(32'h0004_0005, RUN1);
    countHigh(100, h0, h1);
    chk(h0 == 100, "R7 duty equal to period length is always active", h0, 100);
    startCh0(32'h0004_0000, RUN1);
    countHigh(100, h0, h1);
    chk(h0 == 0, "R7 zero duty is always inactive", h0, 0);
    startCh0(32'h0004_0004, RUN1);
    countHigh(100, h0, h1);
    chk(h0 == 80, "R5 duty 4 of period 5", h0, 80);
  endtask

  task automatic testPolarity;
    int h0, h1;
    startCh0(32'h0009_0003, EN | GATE | 32'hF);
    countHigh(100, h0, h1);
    chk(h0 == 70, "R6 inverted output high outside duty", h0, 70);
  endtask

  task automatic testBypass;
    regWrite(4'h0, BYP);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      chk(pwmOut[0] == 1'b1, "R8 bypass follows clock high", pwmOut[0], 1);
      chk(pwmOut[1] == 1'b1, "R10 other channel unaffected by bypass", pwmOut[1], 1);
      @(negedge clk); #2;
      chk(pwmOut[0] == 1'b0, "R8 bypass follows clock low", pwmOut[0], 0);
    end
    regWrite(4'h0, BYP | ACT | 32'h5);
    @(posedge clk); #2;
    chk(pwmOut[0] == 1'b1, "R8 bypass overrides invalid code high", pwmOut[0], 1);
    @(negedge clk); #2;
    chk(pwmOut[0] == 1'b0, "R8 bypass overrides invalid code low", pwmOut[0], 0);
    regWrite(4'h0, 32'h0);
  endtask

  task automatic testDeferred;
    logic [31:0] d;
    int n;
    startCh0(32'h00C7_0032, RUN1);
    regWrite(4'h4, 32'h0009_0003);
    regRead(4'h0, d);
    chk(d == (RUN1 | 32'h1000_0000), "R9 ready flag set while pending", d, RUN1 | 32'h1000_0000);
    runLen(0, 1'b1, 300, n);
    runLen(0, 1'b0, 300, n);
    chk(n == 150, "R9 old cycle completes before update", n, 150);
    runLen(0, 1'b1, 300, n);
    chk(n == 3, "R9 new duty after boundary", n, 3);
    runLen(0, 1'b0, 300, n);
    chk(n == 7, "R9 new period after boundary", n, 7);
    regRead(4'h0, d);
    chk(d == RUN1, "R9 ready flag cleared after load", d, RUN1);
  endtask

  task automatic testChannel1;
    int h0, h1;
    regWrite(4'h0, ACT);
    regWrite(4'h8, 32'h0004_0002);
    regWrite(4'h0, (RUN1 << 15) | ACT);
    countHigh(100, h0, h1);
    chk(h1 == 40, "R10 channel 1 waveform", h1, 40);
    chk(h0 == 0, "R10 channel 0 stays stopped", h0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testGating();
    testPrescale();
    testInvalid();
    testDutyEdges();
    testPolarity();
    testBypass();
    testDeferred();
    testChannel1();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule